// File: doc/BRIEF.md
# Flash Program/Erase Busy and Status Engine

This block tracks the internal write state of a word-wide NOR flash array while an embedded program or erase runs. When a start pulse arrives, it captures the operation kind and the word being written. It then runs a clock-cycle timer whose length depends on the operation. The ready/busy line is pulled low for the whole run. The timer lengths are parameters, so a simulation can use short runs and silicon can use real microsecond and millisecond values.

While the engine is busy, a read access returns a status word in place of array data. Bit 7 carries the polling value: for a word program it is the complement of bit 7 of the word being written, and for any erase it is 0. Bit 6 flips once for each new read access. All other bits read 0. When the run ends, the engine drops busy, emits a one-cycle done pulse and passes array data through again. The host does nothing to bring this about.

A synchronous halt input aborts the run. It takes effect only after it has been held low for a minimum number of cycles. While halt is low, the data output is not driven.

Top module: `flash_busy_status`

## Requirements
- R1: A start pulse accepted while idle, not halted and out of reset raises `ryby_oe` at the next clock edge. `ryby_oe` then stays high for exactly the cycle count set for the operation. The operation codes are: `op` = 2'b00 word program, 2'b01 page erase, 2'b10 block erase, 2'b11 chip erase.
- R2: A start pulse that arrives while an operation runs has no effect. The run length and the captured polling value stay as they were.
- R3: `done` is high for exactly one cycle. That cycle is the first cycle in which `ryby_oe` is low after a run that ends normally.
- R4: During a word program, bit 7 of a read returns the complement of bit 7 of `wr_data` as captured at start.
- R5: During any erase, bit 7 of a read returns 0.
- R6: While busy, the first read access after a start returns bit 6 = 1, and each later access returns the opposite value. A strobe held over several cycles counts as one access and keeps bit 6 unchanged.
- R7: In a status word, every bit other than bits 7 and 6 reads 0.
- R8: When the engine is idle, a read returns `arr_data` as sampled at the clock edge that starts the access.
- R9: `dout_oe` goes high one cycle after `ce_n` and `oe_n` are both low with `halt_n` high. It is low in every other case, which includes any cycle after `halt_n` was sampled low.
- R10: If `halt_n` is low for HALT_MIN consecutive clock edges, the run is aborted at the last of those edges, and no `done` pulse follows. A shorter low pulse leaves the run going.
- R11: A start pulse while `halt_n` is low is ignored.
- R12: An asserted `rst_n` clears `ryby_oe`, `done` and `dout_oe` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request that starts an operation |
| op | input | 2 | Operation kind (see R1) |
| wr_data | input | DW | Last word loaded, used for polling |
| halt_n | input | 1 | Active-low abort request, filtered |
| ce_n | input | 1 | Active-low chip select for reads |
| oe_n | input | 1 | Active-low output enable for reads |
| arr_data | input | DW | Array word for idle reads |
| dout | output | DW | Registered read data |
| dout_oe | output | 1 | Drive enable for `dout` |
| ryby_oe | output | 1 | 1 = pull the open-drain ready/busy line low |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-cycle width of done and the rule that done only ever follows busy. They also cover the start-to-busy step, the quiet state after an abort, the strobe history behind `dout_oe`, the zero bits of the status word, the low polling bit during erase, and the bit 6 flip-or-hold rule.

Other behaviour needs the bench's scenarios to show it. That includes the exact run length for each operation code and the complemented polling bit for several data words. It also includes the pass-through of array data after completion, a start rejected mid-run, the contrast between a halt pulse just too short and one just long enough, and the asynchronous reset.

// File: rtl/fse_pkg.sv
package fse_pkg;

  typedef enum logic [1:0] {
    OP_WORD  = 2'b00,
    OP_PAGE  = 2'b01,
    OP_BLOCK = 2'b10,
    OP_CHIP  = 2'b11
  } op_e;

  // Status bit positions; software polling depends on them.
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  function automatic int unsigned max_of4(input int unsigned a, b, c, d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fse_halt_filter.sv
module fse_halt_filter #(
  parameter int HALT_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_n,
  output logic abort
);

  localparam int HW = (HALT_MIN < 2) ? 1 : $clog2(HALT_MIN);
  localparam logic [HW-1:0] LAST = HW'(HALT_MIN - 1);

  logic [HW-1:0] hcnt_q, hcnt_d;

  assign abort = !halt_n && (hcnt_q == LAST);

  always_comb begin
    hcnt_d = hcnt_q;
    if (halt_n)              hcnt_d = '0;
    else if (hcnt_q != LAST) hcnt_d = hcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= hcnt_d;
  end

  // R10: an abort needs halt held low on the previous edge as well
  a_r10_abort_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(!halt_n));

endmodule

// File: rtl/fse_busy_timer.sv
module fse_busy_timer
  import fse_pkg::*;
#(
  parameter int unsigned PROG_CYC  = 30,
  parameter int unsigned PAGE_CYC  = 50,
  parameter int unsigned BLOCK_CYC = 60,
  parameter int unsigned CHIP_CYC  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [1:0] op,
  input  logic       abort,
  output logic       busy,
  output logic       done
);

  localparam int unsigned MAXD = max_of4(PROG_CYC, PAGE_CYC, BLOCK_CYC, CHIP_CYC);
  localparam int CW = $clog2(MAXD + 1);

  logic [CW-1:0] cnt_q, cnt_d, load_val;
  logic          busy_q, busy_d, done_q, done_d;

  always_comb begin
    case (op)
      OP_WORD:  load_val = CW'(PROG_CYC - 1);
      OP_PAGE:  load_val = CW'(PAGE_CYC - 1);
      OP_BLOCK: load_val = CW'(BLOCK_CYC - 1);
      default:  load_val = CW'(CHIP_CYC - 1);
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (go) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R3: completion pulse lasts one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R3: completion pulse appears only right after a busy cycle
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R1: an accepted start makes the engine busy
  a_r1_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy_q && !abort) |=> busy_q);
  // R10: an abort leaves neither busy nor done
  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy_q && !done_q));

endmodule

// File: rtl/fse_poll_toggle.sv
module fse_poll_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic en,
  input  logic clr,
  output logic tog_next
);

  logic rd_q, tog_q, rise;

  assign rise = rd && !rd_q;

  always_comb begin
    tog_next = tog_q;
    if (clr)              tog_next = 1'b0;
    else if (en && rise)  tog_next = !tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q  <= rd;
      tog_q <= tog_next;
    end
  end

  // R6: a new access while busy flips the toggle bit
  a_r6_flip_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd && !rd_q && !clr) |=> (tog_q != $past(tog_q)));
  // R6: a held strobe leaves the toggle bit alone
  a_r6_hold_on_long_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rd_q && !clr) |=> $stable(tog_q));

endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import fse_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int unsigned PROG_CYC  = 30,
  parameter int unsigned PAGE_CYC  = 50,
  parameter int unsigned BLOCK_CYC = 60,
  parameter int unsigned CHIP_CYC  = 200,
  parameter int          HALT_MIN  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [DW-1:0] wr_data,
  input  logic          halt_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          ryby_oe,
  output logic          done
);

  localparam logic [DW-1:0] STAT_MASK = (DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT);

  logic          busy, abort, go, rd, tog_next;
  logic          erase_q, erase_d, poll_q, poll_d, oe_q, oe_d;
  logic [DW-1:0] dout_q, dout_d, stat;

  assign rd = !ce_n && !oe_n;
  assign go = start && halt_n && !busy;

  fse_halt_filter #(.HALT_MIN(HALT_MIN)) i_halt (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .abort(abort)
  );

  fse_busy_timer #(
    .PROG_CYC(PROG_CYC), .PAGE_CYC(PAGE_CYC),
    .BLOCK_CYC(BLOCK_CYC), .CHIP_CYC(CHIP_CYC)
  ) i_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .abort(abort),
    .busy(busy), .done(done)
  );

  fse_poll_toggle i_tog (
    .clk(clk), .rst_n(rst_n), .rd(rd), .en(busy), .clr(go),
    .tog_next(tog_next)
  );

  always_comb begin
    erase_d = erase_q;
    poll_d  = poll_q;
    if (go) begin
      erase_d = (op != OP_WORD);
      poll_d  = !wr_data[POLL_BIT];
    end
  end

  always_comb begin
    stat           = '0;
    stat[POLL_BIT] = erase_q ? 1'b0 : poll_q;
    stat[TOG_BIT]  = tog_next;
  end

  always_comb begin
    dout_d = dout_q;
    if (rd) dout_d = busy ? stat : arr_data;
    oe_d = rd && halt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      poll_q  <= 1'b0;
      oe_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      erase_q <= erase_d;
      poll_q  <= poll_d;
      oe_q    <= oe_d;
      dout_q  <= dout_d;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;
  assign ryby_oe = busy;

  // R9: output drive only follows an unhalted read strobe
  a_r9_oe_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!ce_n && !oe_n && halt_n));
  // R7: non-status bits of a status word are zero
  a_r7_status_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(busy)) |-> ((dout & ~STAT_MASK) == '0));
  // R5: polling bit is low during an erase
  a_r5_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(busy && erase_q)) |-> !dout[POLL_BIT]);
  // R11: no start is taken while halt is low
  a_r11_halt_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !halt_n) |=> !busy);

endmodule

// File: tb/test_flash_busy_status.sv
module test_flash_busy_status;

  localparam int DW = 16;
  localparam int unsigned T_PROG = 20, T_PAGE = 40, T_BLOCK = 48, T_CHIP = 90;
  localparam int HMIN = 4;

  // entry: [9:8] op code, [7:0] low byte of the written word
  localparam logic [9:0] VEC [0:5] = '{
    {2'b00, 8'h80}, {2'b00, 8'h00}, {2'b01, 8'h3C},
    {2'b10, 8'hFF}, {2'b11, 8'h00}, {2'b00, 8'h7F}
  };

  logic clk = 1'b0;
  logic rst_n, start, halt_n, ce_n, oe_n;
  logic [1:0] op;
  logic [DW-1:0] wr_data, arr_data, dout;
  logic dout_oe, ryby_oe, done;

  int n_chk = 0, n_fail = 0;
  int busy_cycles = 0, done_hits = 0;

  always #10 clk = !clk;

  flash_busy_status #(
    .DW(DW), .PROG_CYC(T_PROG), .PAGE_CYC(T_PAGE),
    .BLOCK_CYC(T_BLOCK), .CHIP_CYC(T_CHIP), .HALT_MIN(HMIN)
  ) i_flash_busy_status (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wr_data(wr_data),
    .halt_n(halt_n), .ce_n(ce_n), .oe_n(oe_n), .arr_data(arr_data),
    .dout(dout), .dout_oe(dout_oe), .ryby_oe(ryby_oe), .done(done)
  );

  function automatic int unsigned dur_of(input logic [1:0] code);
    case (code)
      2'b00:   return T_PROG;
      2'b01:   return T_PAGE;
      2'b10:   return T_BLOCK;
      default: return T_CHIP;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (ryby_oe) busy_cycles++;
    if (done)    done_hits++;
  endtask

  task automatic strobe(input logic on);
    ce_n = !on;
    oe_n = !on;
  endtask

  task automatic run_vec(input logic [9:0] v);
    logic [1:0] c;
    logic       exp7;
    logic [DW-1:0] a;
    c    = v[9:8];
    exp7 = (c == 2'b00) ? !v[7] : 1'b0;
    @(negedge clk);
    start = 1'b1; op = c; wr_data = {8'hC3, v[7:0]};
    busy_cycles = 0; done_hits = 0;
    tick();
    start = 1'b0;
    chk(ryby_oe == 1'b1, "R1 busy after start", ryby_oe, 1);
    strobe(1'b1); arr_data = 16'h1234;
    tick();
    chk(dout_oe == 1'b1, "R9 drive on read", dout_oe, 1);
    chk(dout[7] == exp7, (c == 2'b00) ? "R4 program poll bit" : "R5 erase poll bit", dout[7], exp7);
    chk(dout[6] == 1'b1, "R6 first toggle", dout[6], 1);
    chk((dout & 16'hFF3F) == '0, "R7 other bits zero", dout, dout & 16'h00C0);
    tick();
    chk(dout[6] == 1'b1, "R6 held strobe stable", dout[6], 1);
    strobe(1'b0);
    tick();
    chk(dout_oe == 1'b0, "R9 no drive without read", dout_oe, 0);
    strobe(1'b1);
    tick();
    chk(dout[6] == 1'b0, "R6 second toggle", dout[6], 0);
    strobe(1'b0);
    while (ryby_oe) tick();
    chk(busy_cycles == dur_of(c), "R1 run length", busy_cycles, dur_of(c));
    chk(done == 1'b1, "R3 done at end", done, 1);
    tick();
    chk(done == 1'b0 && done_hits == 1, "R3 done single cycle", done_hits, 1);
    a = 16'hA500 | {8'h00, v[7:0]};
    arr_data = a; strobe(1'b1);
    tick();
    chk(dout == a, "R8 array data after run", dout, a);
    strobe(1'b0);
    tick();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; wr_data = '0; halt_n = 1'b1;
    ce_n = 1'b1; oe_n = 1'b1; arr_data = '0;
    repeat (3) @(negedge clk);
    chk(ryby_oe == 0 && done == 0 && dout_oe == 0, "R12 reset state",
        {ryby_oe, done, dout_oe}, 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 6; i++) run_vec(VEC[i]);

    // R2: start during a run is ignored
    @(negedge clk);
    start = 1'b1; op = 2'b00; wr_data = 16'h0000;
    busy_cycles = 0; done_hits = 0;
    tick(); start = 1'b0;
    tick(); tick();
    start = 1'b1; op = 2'b11; wr_data = 16'h0080;
    tick(); start = 1'b0;
    strobe(1'b1);
    tick();
    chk(dout[7] == 1'b1, "R2 poll bit kept", dout[7], 1);
    strobe(1'b0);
    while (ryby_oe) tick();
    chk(busy_cycles == T_PROG, "R2 run length kept", busy_cycles, T_PROG);
    tick();

    // R10: halt pulse one cycle short, then long enough
    start = 1'b1; op = 2'b10; wr_data = 16'h00FF;
    busy_cycles = 0; done_hits = 0;
    tick(); start = 1'b0;
    halt_n = 1'b0; strobe(1'b1);
    tick();
    chk(dout_oe == 1'b0, "R9 no drive while halted", dout_oe, 0);
    tick(); tick();
    halt_n = 1'b1; strobe(1'b0);
    tick();
    chk(ryby_oe == 1'b1, "R10 short halt ignored", ryby_oe, 1);
    halt_n = 1'b0;
    tick(); tick(); tick();
    chk(ryby_oe == 1'b1, "R10 still busy before min width", ryby_oe, 1);
    tick();
    chk(ryby_oe == 1'b0, "R10 abort after min width", ryby_oe, 0);
    tick();
    chk(done_hits == 0, "R10 no done after abort", done_hits, 0);

    // R11: start while halt low
    start = 1'b1; op = 2'b00;
    tick(); start = 1'b0;
    chk(ryby_oe == 1'b0, "R11 start ignored while halted", ryby_oe, 0);
    halt_n = 1'b1;
    tick();

    // R12: asynchronous reset mid-run
    start = 1'b1; op = 2'b11;
    tick(); start = 1'b0;
    strobe(1'b1);
    tick();
    #3 rst_n = 1'b0;
    #1;
    chk(ryby_oe == 0 && done == 0 && dout_oe == 0, "R12 async reset",
        {ryby_oe, done, dout_oe}, 0);
    strobe(1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(ryby_oe == 1'b0, "R12 stays idle after reset", ryby_oe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule